// File: doc/BRIEF.md
# Management Status Word with Sticky Event Bits

This block supplies the read-only status word at register address 1 of a Fast Ethernet transceiver's management space. The 16-bit word combines three kinds of bit:

- constant capability flags, set by parameters;
- a live mirror of auto-negotiation completion;
- three sticky bits that remember link loss, jabber and remote fault until software looks at them.

The serial management engine sits outside this block. It decodes a read of register 1 and sends a one-cycle strobe. The block presents the word combinationally, so the engine can shift out the values as they stood before the read. On the following clock edge, the sticky bits are then cleared or refreshed.

The link bit latches low. Once the link drops, the bit reads 0 until a read occurs while the link is up. The jabber and remote-fault bits latch high. When an event coincides with a read strobe, the event takes precedence, so no event is lost.

Top module: `mstat_bmsr`

## Requirements
- R1: Bit 15 reads 0; bits 14, 13, 12, 11 and bit 3 read 1 (default capability parameters), giving a constant part of 0x7808.
- R2: Bits 10 down to 6 always read 0, whatever the inputs or history.
- R3: Bit 5 equals the auto-negotiation-complete input in the same cycle.
- R4: After reset, bits 5, 4, 2 and 1 read 0 (with auto-negotiation input low) and all three sticky outputs are 0.
- R5: Bit 2 (link) becomes 0 on the edge after the link input is sampled low. It stays 0 after the link recovers, until a read strobe is sampled with the link high, which sets it to 1 on that edge.
- R6: Bit 1 (jabber) becomes 1 on the edge after the jabber input is sampled high. It stays 1 until a read strobe is sampled with jabber low, which clears it on that edge.
- R7: Bit 4 (remote fault) becomes 1 on the edge after the partner's remote-fault input is sampled high. It is cleared by a read strobe sampled with that input low, or by reset.
- R8: During a read strobe cycle, the read data shows the sticky values from before the read. The clear or refresh appears from the next cycle on.
- R9: When an event coincides with a read strobe, the event wins. Link low keeps bit 2 at 0, and jabber or remote fault high keeps its bit at 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Live link-up level |
| jabber_i | input | 1 | Jabber-detect pulse |
| an_done_i | input | 1 | Auto-negotiation complete level |
| lp_rfault_i | input | 1 | Link partner's remote-fault bit |
| rd_stb_i | input | 1 | One-cycle read strobe for register 1 |
| rdata_o | output | 16 | Status word |
| sticky_link_o | output | 1 | Latched link bit |
| sticky_jabber_o | output | 1 | Latched jabber bit |
| sticky_rfault_o | output | 1 | Latched remote-fault bit |

## Verification
The assertions check four sticky-bit rules on every cycle:

- an event forces its bit on the next edge;
- a read with no event releases the bit;
- a quiet cycle leaves the bit unchanged;
- an event at a port shows up at the sticky output one edge later.

Only the bench's scenarios can show that the read data carries the pre-read values during the strobe cycle. The same holds for the exact 16-bit word across sequences of link loss, recovery and re-read, and for reset clearing a standing remote fault.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   localparam int unsigned WORD_W     = 16;
   localparam int unsigned N_STICKY   = 3;
   // bit positions in the status word (decoded by management software)
   localparam int unsigned B_T4       = 15;
   localparam int unsigned B_TX_FD    = 14;
   localparam int unsigned B_TX_HD    = 13;
   localparam int unsigned B_10_FD    = 12;
   localparam int unsigned B_10_HD    = 11;
   localparam int unsigned B_RSV_HI   = 10;
   localparam int unsigned B_RSV_LO   = 7;
   localparam int unsigned B_PRE_SUP  = 6;
   localparam int unsigned B_AN_DONE  = 5;
   localparam int unsigned B_RFAULT   = 4;
   localparam int unsigned B_AN_ABLE  = 3;
   localparam int unsigned B_LINK     = 2;
   localparam int unsigned B_JABBER   = 1;
   localparam int unsigned B_EXT_CAP  = 0;
   // sticky slot indices
   localparam int unsigned S_LINK     = 0;
   localparam int unsigned S_JABBER   = 1;
   localparam int unsigned S_RFAULT   = 2;

   typedef struct packed {
      logic rfault;
      logic jabber;
      logic link;
   } sticky_t;
endpackage

// File: rtl/mstat_sticky_cell.sv
module mstat_sticky_cell #(
   parameter bit LATCH_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   input  logic rd_stb_i,
   output logic q_o
);
   localparam logic HELD = LATCH_HIGH ? 1'b1 : 1'b0;

   logic evt;

   generate
      if (LATCH_HIGH) begin : g_high
         assign evt = cond_i;
      end else begin : g_low
         assign evt = ~cond_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        q_o <= 1'b0;
      else if (evt)      q_o <= HELD;
      else if (rd_stb_i) q_o <= ~HELD;
   end

   AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !evt) |=> (q_o == ~HELD)) else $error("read release");  // R8
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb_i && !evt) |=> $stable(q_o)) else $error("quiet hold");     // R5
endmodule

// File: rtl/mstat_word_pack.sv
module mstat_word_pack
   import mstat_pkg::*;
#(
   parameter bit CAP_T4     = 1'b0,
   parameter bit CAP_TX_FD  = 1'b1,
   parameter bit CAP_TX_HD  = 1'b1,
   parameter bit CAP_10_FD  = 1'b1,
   parameter bit CAP_10_HD  = 1'b1,
   parameter bit CAP_PRE_SUP = 1'b0,
   parameter bit CAP_AN_ABLE = 1'b1
) (
   input  sticky_t              st_i,
   input  logic                 an_done_i,
   output logic [WORD_W-1:0]    word_o
);
   always_comb begin
      word_o                     = '0;
      word_o[B_T4]               = CAP_T4;
      word_o[B_TX_FD]            = CAP_TX_FD;
      word_o[B_TX_HD]            = CAP_TX_HD;
      word_o[B_10_FD]            = CAP_10_FD;
      word_o[B_10_HD]            = CAP_10_HD;
      word_o[B_RSV_HI:B_RSV_LO]  = '0;
      word_o[B_PRE_SUP]          = CAP_PRE_SUP;
      word_o[B_AN_DONE]          = an_done_i;
      word_o[B_RFAULT]           = st_i.rfault;
      word_o[B_AN_ABLE]          = CAP_AN_ABLE;
      word_o[B_LINK]             = st_i.link;
      word_o[B_JABBER]           = st_i.jabber;
      word_o[B_EXT_CAP]          = 1'b0;
   end
endmodule

// File: rtl/mstat_bmsr.sv
module mstat_bmsr
   import mstat_pkg::*;
#(
   parameter int unsigned REG_W = 16,
   parameter bit CAP_T4      = 1'b0,
   parameter bit CAP_TX_FD   = 1'b1,
   parameter bit CAP_TX_HD   = 1'b1,
   parameter bit CAP_10_FD   = 1'b1,
   parameter bit CAP_10_HD   = 1'b1,
   parameter bit CAP_AN_ABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_up_i,
   input  logic             jabber_i,
   input  logic             an_done_i,
   input  logic             lp_rfault_i,
   input  logic             rd_stb_i,
   output logic [REG_W-1:0] rdata_o,
   output logic             sticky_link_o,
   output logic             sticky_jabber_o,
   output logic             sticky_rfault_o
);
   // slot polarity: link latches low, jabber and remote fault latch high
   localparam logic [N_STICKY-1:0] HIGH_MASK = 3'b110;

   initial begin
      assert (REG_W == WORD_W) else $error("REG_W must be 16");
   end

   logic [N_STICKY-1:0] cond_vec;
   logic [N_STICKY-1:0] q_vec;
   sticky_t             st;
   logic [WORD_W-1:0]   word;

   assign cond_vec[S_LINK]   = link_up_i;
   assign cond_vec[S_JABBER] = jabber_i;
   assign cond_vec[S_RFAULT] = lp_rfault_i;

   generate
      for (genvar i = 0; i < N_STICKY; i++) begin : g_cell
         mstat_sticky_cell #(.LATCH_HIGH(HIGH_MASK[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond_i   (cond_vec[i]),
            .rd_stb_i (rd_stb_i),
            .q_o      (q_vec[i])
         );
      end
   endgenerate

   assign st.link   = q_vec[S_LINK];
   assign st.jabber = q_vec[S_JABBER];
   assign st.rfault = q_vec[S_RFAULT];

   mstat_word_pack #(
      .CAP_T4      (CAP_T4),
      .CAP_TX_FD   (CAP_TX_FD),
      .CAP_TX_HD   (CAP_TX_HD),
      .CAP_10_FD   (CAP_10_FD),
      .CAP_10_HD   (CAP_10_HD),
      .CAP_PRE_SUP (1'b0),
      .CAP_AN_ABLE (CAP_AN_ABLE)
   ) u_pack (
      .st_i      (st),
      .an_done_i (an_done_i),
      .word_o    (word)
   );

   assign rdata_o         = word[REG_W-1:0];
   assign sticky_link_o   = st.link;
   assign sticky_jabber_o = st.jabber;
   assign sticky_rfault_o = st.rfault;

   AST_LINK_LOSS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up_i |=> !sticky_link_o) else $error("link loss missed");      // R5
   AST_JABBER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      jabber_i |=> sticky_jabber_o) else $error("jabber missed");          // R6
   AST_RFAULT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      lp_rfault_i |=> sticky_rfault_o) else $error("remote fault missed"); // R7
   AST_READ_WINS_NOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && jabber_i) |=> sticky_jabber_o) else $error("read beat event"); // R9
endmodule

// File: tb/tb_mstat_bmsr.sv
module tb_mstat_bmsr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up_i = 1'b0, jabber_i = 1'b0, an_done_i = 1'b0;
   logic        lp_rfault_i = 1'b0, rd_stb_i = 1'b0;
   logic [15:0] rdata_o;
   logic        sticky_link_o, sticky_jabber_o, sticky_rfault_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   mstat_bmsr dut (
      .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .jabber_i(jabber_i),
      .an_done_i(an_done_i), .lp_rfault_i(lp_rfault_i), .rd_stb_i(rd_stb_i),
      .rdata_o(rdata_o), .sticky_link_o(sticky_link_o),
      .sticky_jabber_o(sticky_jabber_o), .sticky_rfault_o(sticky_rfault_o)
   );

   // {link, jabber, an_done, rfault, rd_stb, expected rdata before the edge}
   localparam int NV = 17;
   localparam logic [20:0] VEC [NV] = '{
      {5'b10000, 16'h7808},  // link up, not yet read: R5
      {5'b10001, 16'h7808},  // read with link up, pre-read value: R8
      {5'b10100, 16'h782C},  // link bit set, an done: R3
      {5'b00100, 16'h782C},  // link drops
      {5'b10100, 16'h7828},  // recovered, still latched low: R5
      {5'b10101, 16'h7828},  // read refreshes
      {5'b11100, 16'h782C},  // jabber pulse
      {5'b10100, 16'h782E},  // jabber held: R6
      {5'b10101, 16'h782E},  // read clears jabber
      {5'b10100, 16'h782C},
      {5'b10110, 16'h782C},  // remote fault arrives
      {5'b10111, 16'h783C},  // read while fault persists: R9
      {5'b10100, 16'h783C},  // fault still latched: R7
      {5'b10101, 16'h783C},  // read clears fault
      {5'b11101, 16'h782C},  // jabber with read: R9
      {5'b00101, 16'h782E},  // link loss with read: R9
      {5'b10000, 16'h7808}   // both held results visible
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R4 reset state
      chk("R4 word", rdata_o, 16'h7808);
      chk("R4 sticky", {13'd0, sticky_rfault_o, sticky_jabber_o, sticky_link_o}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         {link_up_i, jabber_i, an_done_i, lp_rfault_i, rd_stb_i} = VEC[k][20:16];
         #1;
         // R1 R2 R3 R5 R6 R7 R8 R9 full word check
         chk($sformatf("R8 vector %0d", k), rdata_o, VEC[k][15:0]);
         chk("R1 capability", rdata_o & 16'hF808, 16'h7808);
         chk("R2 reserved", rdata_o & 16'h07C0, 16'h0000);
         chk("R3 an mirror", {15'd0, rdata_o[5]}, {15'd0, an_done_i});
      end
      @(negedge clk);
      {link_up_i, jabber_i, an_done_i, lp_rfault_i, rd_stb_i} = 5'b10000;
      #1;
      // after vector 14 jabber kept, vector 15 read cleared it; link lost in read cycle
      chk("R9 link held low", {15'd0, sticky_link_o}, 16'h0000);
      chk("R6 jabber cleared", {15'd0, sticky_jabber_o}, 16'h0000);

      // R7: reset clears a standing remote fault
      lp_rfault_i = 1'b1;
      @(negedge clk);
      lp_rfault_i = 1'b0;
      #1;
      chk("R7 fault set", {15'd0, sticky_rfault_o}, 16'h0001);
      rst_n = 1'b0;
      @(negedge clk);
      #1;
      chk("R7 reset clears", {15'd0, sticky_rfault_o}, 16'h0000);
      chk("R4 reset word", rdata_o, 16'h7808);
      rst_n = 1'b1;

      // R5: link bit follows after a read while up
      @(negedge clk);
      rd_stb_i = 1'b1;
      @(negedge clk);
      rd_stb_i = 1'b0;
      #1;
      chk("R5 link set by read", {15'd0, sticky_link_o}, 16'h0001);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule